// File: doc/BRIEF.md
# Multicycle Load/Store Sequencer

This block steps a multicycle datapath through the phases of each instruction. It holds a 3-bit phase register and decodes the 6-bit opcode of the instruction register. From these it produces the strobes that steer the datapath: write enables for PC, IR, memory and register file, and selects for the PC source, the ALU inputs, the ALU function, the destination register and the write-back source. It covers only loads and stores. A load takes five phases and a store takes four. Any other opcode goes back to fetch after decode.

The controller is a Moore machine built from two lookup tables. The first table maps the current phase and the opcode to the next phase. It has many entries, each only 3 bits wide. The second table maps the phase alone to a 12-bit control word, so the strobes never see the opcode directly. Fetch and decode are shared by every instruction. The current phase code is also brought out on a debug port so the length of each instruction can be measured from outside.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low the phase code is 0 (fetch). It becomes 0 at once when `rst_n` falls, even in the middle of an instruction.
- R2: Phase 0 (fetch) always goes to phase 1 (decode) on the next clock, whatever the opcode.
- R3: In decode, opcode 43 leads to phase 2 (first store phase) and opcode 35 leads to phase 4 (first load phase).
- R4: In decode, any other opcode leads back to phase 0. Decode asserts none of the write enables `pc_we`, `mem_we`, `ir_we`, `rf_we`.
- R5: A store runs through phases 0,1,2,3 and then returns to 0, which is 4 cycles. `mem_we` is high only in phase 3. Phase 3 keeps `alu_a_sel`=1 and `alu_b_sel`=2'b10.
- R6: A load runs through phases 0,1,4,5,6 and then returns to 0, which is 5 cycles. Phases 4 and 5 assert no write enable.
- R7: Fetch drives `ir_we`=1, `pc_we`=1, `pc_sel`=0 (ALU result), `alu_a_sel`=0 (PC), `alu_b_sel`=2'b01 (constant 4) and `alu_op`=2'b00 (add). All other outputs are 0.
- R8: Phases 2, 4 and 5 drive `alu_a_sel`=1 (A latch), `alu_b_sel`=2'b10 (sign-extended immediate) and `alu_op`=2'b00, with no write enable.
- R9: Phase 6 drives `rf_we`=1, `wb_sel`=1 (data register) and `dst_sel`=0 (rt field). All other outputs are 0.
- R10: The outputs depend only on the phase. Changing `opcode` within a cycle leaves every control output unchanged.
- R11: At most one of `ir_we`, `mem_we` and `rf_we` is high in any cycle.
- R12: The phase code never takes the value 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | PC write enable |
| mem_we | output | 1 | Data memory write enable |
| ir_we | output | 1 | Instruction register write enable |
| pc_sel | output | 1 | PC source: 0 = ALU result |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = A latch |
| alu_b_sel | output | 2 | ALU B input: 00 = B latch, 01 = constant 4, 10 = sign-extended immediate |
| alu_op | output | 2 | ALU function: 00 = add |
| dst_sel | output | 1 | Destination register: 0 = rt, 1 = rd |
| wb_sel | output | 1 | Register write data: 0 = ALU result, 1 = data register |
| rf_we | output | 1 | Register file write enable |
| state_dbg | output | 3 | Current phase code |

## Verification
The assertions check on every cycle that each phase goes to the right next phase, including the three-way branch in decode. They also check that memory and register writes happen only in the cycle after the phase that prepares them, that the three write strobes never overlap, and that code 7 never appears. Some things only the bench scenarios can show. These are the full control word in each phase, the 4-cycle and 5-cycle instruction lengths counted from the debug port, the independence of the outputs from opcode changes within a cycle, and the immediate return to fetch when reset is asserted mid-instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int PH_W = 3;

  typedef enum logic [PH_W-1:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_ST_ADR = 3'd2,
    PH_ST_WR  = 3'd3,
    PH_LD_ADR = 3'd4,
    PH_LD_RD  = 3'd5,
    PH_LD_WB  = 3'd6,
    PH_SPARE  = 3'd7
  } mc_phase_e;

  localparam logic       PCSRC_ALU = 1'b0;
  localparam logic       ASRC_PC   = 1'b0;
  localparam logic       ASRC_REG  = 1'b1;
  localparam logic [1:0] BSRC_REG  = 2'b00;
  localparam logic [1:0] BSRC_FOUR = 2'b01;
  localparam logic [1:0] BSRC_IMM  = 2'b10;
  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic       DST_RT    = 1'b0;
  localparam logic       WB_DATA   = 1'b1;

  typedef struct packed {
    logic       pc_we;
    logic       mem_we;
    logic       ir_we;
    logic       pc_sel;
    logic       a_sel;
    logic [1:0] b_sel;
    logic [1:0] alu_op;
    logic       dst_sel;
    logic       wb_sel;
    logic       rf_we;
  } mc_ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign srst_n = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mc_next_lut.sv
module mc_next_lut
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W    = 6,
  parameter logic [OPC_W-1:0] LOAD_OP  = 6'd35,
  parameter logic [OPC_W-1:0] STORE_OP = 6'd43
) (
  input  mc_phase_e        cur,
  input  logic [OPC_W-1:0] opc,
  output mc_phase_e        nxt
);

  // Deep, narrow table: (phase, opcode) -> phase. Every entry defined.
  always_comb begin
    nxt = PH_FETCH;
    unique case (cur)
      PH_FETCH:  nxt = PH_DECODE;
      PH_DECODE: begin
        if (opc == STORE_OP)     nxt = PH_ST_ADR;
        else if (opc == LOAD_OP) nxt = PH_LD_ADR;
        else                     nxt = PH_FETCH;
      end
      PH_ST_ADR: nxt = PH_ST_WR;
      PH_ST_WR:  nxt = PH_FETCH;
      PH_LD_ADR: nxt = PH_LD_RD;
      PH_LD_RD:  nxt = PH_LD_WB;
      PH_LD_WB:  nxt = PH_FETCH;
      PH_SPARE:  nxt = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_lut.sv
module mc_ctrl_lut
  import mc_ctrl_pkg::*;
(
  input  mc_phase_e cur,
  output mc_ctrl_t  word
);

  // Shallow, wide table: phase -> control word. Opcode is not an input.
  always_comb begin
    word        = '0;
    word.alu_op = ALU_ADD;
    unique case (cur)
      PH_FETCH: begin
        word.ir_we  = 1'b1;
        word.pc_we  = 1'b1;
        word.pc_sel = PCSRC_ALU;
        word.a_sel  = ASRC_PC;
        word.b_sel  = BSRC_FOUR;
      end
      PH_DECODE: begin
        word.b_sel = BSRC_REG;
      end
      PH_ST_ADR, PH_LD_ADR, PH_LD_RD: begin
        word.a_sel = ASRC_REG;
        word.b_sel = BSRC_IMM;
      end
      PH_ST_WR: begin
        word.a_sel  = ASRC_REG;
        word.b_sel  = BSRC_IMM;
        word.mem_we = 1'b1;
      end
      PH_LD_WB: begin
        word.rf_we   = 1'b1;
        word.wb_sel  = WB_DATA;
        word.dst_sel = DST_RT;
      end
      PH_SPARE: begin
        word = '0;
      end
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W      = 6,
  parameter logic [OPC_W-1:0] LOAD_OP    = 6'd35,
  parameter logic [OPC_W-1:0] STORE_OP   = 6'd43,
  parameter int               RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_we,
  output logic             mem_we,
  output logic             ir_we,
  output logic             pc_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             dst_sel,
  output logic             wb_sel,
  output logic             rf_we,
  output logic [PH_W-1:0]  state_dbg
);

  logic      rst_q_n;
  mc_phase_e phase_q;
  mc_phase_e phase_d;
  mc_ctrl_t  ctrl;

  mc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  mc_next_lut #(
    .OPC_W    (OPC_W),
    .LOAD_OP  (LOAD_OP),
    .STORE_OP (STORE_OP)
  ) u_next (
    .cur (phase_q),
    .opc (opcode),
    .nxt (phase_d)
  );

  mc_ctrl_lut u_ctrl (
    .cur  (phase_q),
    .word (ctrl)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) phase_q <= PH_FETCH;
    else          phase_q <= phase_d;
  end

  assign pc_we     = ctrl.pc_we;
  assign mem_we    = ctrl.mem_we;
  assign ir_we     = ctrl.ir_we;
  assign pc_sel    = ctrl.pc_sel;
  assign alu_a_sel = ctrl.a_sel;
  assign alu_b_sel = ctrl.b_sel;
  assign alu_op    = ctrl.alu_op;
  assign dst_sel   = ctrl.dst_sel;
  assign wb_sel    = ctrl.wb_sel;
  assign rf_we     = ctrl.rf_we;
  assign state_dbg = phase_q;

  // Phase sequencing checks
  p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_FETCH |=> phase_q == PH_DECODE);

  p_decode_store_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase_q == PH_DECODE && opcode == STORE_OP) |=> phase_q == PH_ST_ADR);

  p_decode_load_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase_q == PH_DECODE && opcode == LOAD_OP) |=> phase_q == PH_LD_ADR);

  p_decode_other_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase_q == PH_DECODE && opcode != LOAD_OP && opcode != STORE_OP)
      |=> phase_q == PH_FETCH);

  p_store_chain_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_ST_ADR |=> phase_q == PH_ST_WR);

  p_store_back_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_ST_WR |=> phase_q == PH_FETCH);

  p_load_adr_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_LD_ADR |=> phase_q == PH_LD_RD);

  p_load_rd_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_LD_RD |=> phase_q == PH_LD_WB);

  p_load_back_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    phase_q == PH_LD_WB |=> phase_q == PH_FETCH);

  // Write strobes follow their preparing phase
  p_mem_we_after_adr_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_we && $past(rst_q_n)) |-> $past(phase_q) == PH_ST_ADR);

  p_rf_we_after_read_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rf_we && $past(rst_q_n)) |-> (wb_sel && $past(phase_q) == PH_LD_RD));

  p_we_onehot_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({ir_we, mem_we, rf_we}));

  p_legal_phase_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    state_dbg != 3'd7);

endmodule

// File: tb/test_mc_seq_ctrl.sv
module test_mc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_we, mem_we, ir_we, pc_sel, alu_a_sel, dst_sel, wb_sel, rf_we;
  logic [1:0] alu_b_sel, alu_op;
  logic [2:0] state_dbg;

  int tests = 0;
  int fails = 0;
  bit saw7  = 1'b0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mc_seq_ctrl i_mc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_we(pc_we), .mem_we(mem_we), .ir_we(ir_we), .pc_sel(pc_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we), .state_dbg(state_dbg)
  );

  wire [11:0] ctrl_bus = {pc_we, mem_we, ir_we, pc_sel, alu_a_sel, alu_b_sel,
                          alu_op, dst_sel, wb_sel, rf_we};

  always @(negedge clk) if (rst_n === 1'b1 && state_dbg === 3'd7) saw7 = 1'b1;

  // Expected control word per phase, field order as ctrl_bus
  function automatic logic [11:0] exp_ctrl(input int s);
    case (s)
      0:       return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0};
      2, 4, 5: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0};
      3:       return {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0};
      6:       return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1};
      default: return 12'h000;
    endcase
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0:       return "R7";
      1:       return "R4";
      3:       return "R5";
      6:       return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic resync();
    opcode = 6'd0;
    rst_n  = 1'b1;
    while (state_dbg !== 3'd1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    chk(state_dbg === 3'd0, "R1", "phase in reset", state_dbg, 0);
    chk(ctrl_bus === exp_ctrl(0), "R1", "word in reset", ctrl_bus, exp_ctrl(0));
    resync();
  endtask

  task automatic run_instr(input logic [5:0] op);
    int    seq[5];
    int    len;
    string rq;
    while (state_dbg !== 3'd0) @(negedge clk);
    opcode = op;
    seq = '{0, 1, 0, 0, 0};
    if (op == 6'd35) begin
      seq = '{0, 1, 4, 5, 6}; len = 5; rq = "R6";
    end else if (op == 6'd43) begin
      seq = '{0, 1, 2, 3, 0}; len = 4; rq = "R5";
    end else begin
      len = 2; rq = "R4";
    end
    for (int i = 0; i < len; i++) begin
      chk(state_dbg === 3'(seq[i]), (i == 1) ? "R2" : (i == 2) ? "R3" : rq,
          "phase", state_dbg, seq[i]);
      chk(ctrl_bus === exp_ctrl(seq[i]), req_of(seq[i]), "control word",
          ctrl_bus, exp_ctrl(seq[i]));
      @(negedge clk);
    end
    chk(state_dbg === 3'd0, rq, "back in fetch after cycle count", state_dbg, 0);
  endtask

  task automatic t_moore();
    while (state_dbg !== 3'd0) @(negedge clk);
    opcode = 6'd43;
    @(negedge clk);
    @(negedge clk);
    opcode = 6'd35;
    #1;
    chk(ctrl_bus === exp_ctrl(2), "R10", "word after opcode 35", ctrl_bus, exp_ctrl(2));
    opcode = 6'd0;
    #1;
    chk(ctrl_bus === exp_ctrl(2), "R10", "word after opcode 0", ctrl_bus, exp_ctrl(2));
    @(negedge clk);
    chk(state_dbg === 3'd3, "R5", "store2 reached", state_dbg, 3);
    opcode = 6'd35;
    #1;
    chk(ctrl_bus === exp_ctrl(3), "R10", "store2 word stable", ctrl_bus, exp_ctrl(3));
    @(negedge clk);
    chk(state_dbg === 3'd0, "R5", "store2 returns", state_dbg, 0);
  endtask

  task automatic t_reset_mid();
    while (state_dbg !== 3'd0) @(negedge clk);
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    chk(state_dbg === 3'd5, "R6", "load2 reached", state_dbg, 5);
    rst_n = 1'b0;
    #1;
    chk(state_dbg === 3'd0, "R1", "async reset mid load", state_dbg, 0);
    chk(rf_we === 1'b0, "R1", "no rf write after reset", rf_we, 0);
    repeat (2) @(negedge clk);
    chk(state_dbg === 3'd0, "R1", "held in reset", state_dbg, 0);
    resync();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "R12", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n  = 1'b0;
    opcode = 6'd0;
    t_reset();
    run_instr(6'd35);
    run_instr(6'd43);
    run_instr(6'd0);
    run_instr(6'd63);
    run_instr(6'd34);
    run_instr(6'd42);
    run_instr(6'd35);
    t_moore();
    t_reset_mid();
    run_instr(6'd43);
    chk(!saw7, "R12", "phase code 7 observed", saw7, 0);
    summary();
  end

endmodule